// File: doc/BRIEF.md
# Bus Trigger and Vector-Clock Timestamper

This block is a debug node placed beside one bus master. It watches the transfer beats the master issues: address, transfer type, burst kind, lock indication and response. A control port reprograms the masked compare conditions between debug runs. When a condition fires, the node takes a shared logical timing vector through a request/grant port. The vector has one 32-bit field for each of four masters and one for the arbiter. The node increments only the field that belongs to its own master and writes the result back in the same granted cycle. It keeps the result as its local stamp and presents it downstream with a description of the event.

A validation engineer reads these stamped records from every node after a run. The stamps order the interactions between masters by causality and not by wall-clock cycles, so a non-deterministic interleaving can be rebuilt and replayed. Besides matching events, the node can stamp on a fixed period. A sticky flag reports any trigger that had to be dropped because an earlier record was still in flight.

Top module: `bus_event_stamper`

## Requirements
- R1: After reset no record is valid, no vector request is raised, the overflow flag is clear and triggering is disabled.
- R2: The control port uses select 0 for the address mask and select 1 for the address compare value. With triggering enabled (mode register, select 4, bit 0) and periodic mode off, a beat with `obs_valid` high fires when `(obs_addr ^ compare) & mask` is zero. A beat with `obs_valid` low never fires.
- R3: Select 2 holds the type compare value in bits 5:0 and the type mask in bits 13:8. The type word is {lock, burst[2:0], trans[1:0]}, with lock in bit 5. A beat fires only if every masked type bit equals the compare value.
- R4: Select 3 holds the response compare value in bits 1:0 and the response mask in bits 9:8. A beat fires only if its masked response equals the compare value, so an error response can serve as the trigger.
- R5: After a trigger, `gv_req` stays high until `gv_gnt` is seen. `gv_we` is high only in a cycle where both are high. In that cycle `gv_wdata` equals `gv_rdata` with field OWN_IDX (bits OWN_IDX*32 upward) increased by one and every other field unchanged.
- R6: The own-field increment wraps from all ones to zero.
- R7: The cycle after the write, `rec_valid` rises with `rec_vec` equal to the written vector. The record also carries the beat's address, its type word and response, and `rec_kind` 0 for a match or 1 for a periodic stamp.
- R8: While `rec_valid` is high and `rec_ready` is low, the record and all its fields hold.
- R9: A trigger that comes while a stamp is in progress, or while a record is pending and not accepted in that cycle, is dropped. It sets the sticky `rec_overflow` and causes no vector access. Any write to the mode register clears the flag.
- R10: With mode bits 0 and 1 both set, stamps fire every P cycles, where P is the period register (select 5), and the beat compare is ignored.
- R11: With mode bit 0 clear, nothing triggers.
- R12: A trigger in the same cycle that downstream accepts the pending record is taken without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 3 | Control register select |
| cfg_wdata | input | 32 | Control write data |
| obs_valid | input | 1 | Observed beat is valid |
| obs_addr | input | ADDR_W | Observed address |
| obs_trans | input | 2 | Observed transfer type |
| obs_burst | input | 3 | Observed burst kind |
| obs_lock | input | 1 | Observed locked indication |
| obs_resp | input | 2 | Observed response |
| gv_req | output | 1 | Request for the global vector |
| gv_gnt | input | 1 | Grant of the global vector |
| gv_rdata | input | NUM_FIELDS*FIELD_W | Current global vector |
| gv_we | output | 1 | Write back of the global vector |
| gv_wdata | output | NUM_FIELDS*FIELD_W | Updated global vector |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_kind | output | 1 | 0 match, 1 periodic |
| rec_addr | output | ADDR_W | Captured address |
| rec_type | output | 6 | Captured {lock, burst, trans} |
| rec_resp | output | 2 | Captured response |
| rec_vec | output | NUM_FIELDS*FIELD_W | Local timing vector |
| rec_overflow | output | 1 | Sticky dropped-trigger flag |

## Verification
Two things can land on the same clock edge: a new trigger, and downstream draining the one pending record. The bench raises `rec_ready` and presents a matching beat at the same falling edge. It then expects the trigger to be taken with the overflow flag still clear, and a fresh record whose own field is one above the previous one. The opposite case holds `rec_ready` low or withholds the grant while a second trigger comes. There the bench expects the flag to set, no further vector request, and the first record to arrive unchanged.

// File: rtl/stamper_pkg.sv
package stamper_pkg;
   localparam int CFG_W  = 32;
   localparam int TYPE_W = 6;
   localparam int RESP_W = 2;

   typedef enum logic [2:0] {
      CSEL_ADDR_MASK = 3'd0,
      CSEL_ADDR_CMP  = 3'd1,
      CSEL_TYPE      = 3'd2,
      CSEL_RESP      = 3'd3,
      CSEL_MODE      = 3'd4,
      CSEL_PERIOD    = 3'd5
   } cfg_sel_e;

   typedef enum logic {
      KIND_MATCH = 1'b0,
      KIND_TICK  = 1'b1
   } kind_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_REQ  = 1'b1
   } gv_state_e;
endpackage

// File: rtl/stamp_trig_unit.sv
module stamp_trig_unit
   import stamper_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_sel,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic                obs_valid,
   input  logic [ADDR_W-1:0]   obs_addr,
   input  logic [TYPE_W-1:0]   obs_type,
   input  logic [RESP_W-1:0]   obs_resp,
   output logic                mode_en,
   output logic                mode_periodic,
   output logic                mode_wr,
   output logic [PERIOD_W-1:0] period,
   output logic                hit
);
   logic [ADDR_W-1:0] addr_mask, addr_cmp;
   logic [TYPE_W-1:0] type_mask, type_cmp;
   logic [RESP_W-1:0] resp_mask, resp_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_mask     <= '0;
         addr_cmp      <= '0;
         type_mask     <= '0;
         type_cmp      <= '0;
         resp_mask     <= '0;
         resp_cmp      <= '0;
         mode_en       <= 1'b0;
         mode_periodic <= 1'b0;
         period        <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            CSEL_ADDR_MASK: addr_mask <= cfg_wdata[ADDR_W-1:0];
            CSEL_ADDR_CMP:  addr_cmp  <= cfg_wdata[ADDR_W-1:0];
            CSEL_TYPE: begin
               type_cmp  <= cfg_wdata[TYPE_W-1:0];
               type_mask <= cfg_wdata[8 +: TYPE_W];
            end
            CSEL_RESP: begin
               resp_cmp  <= cfg_wdata[RESP_W-1:0];
               resp_mask <= cfg_wdata[8 +: RESP_W];
            end
            CSEL_MODE: begin
               mode_en       <= cfg_wdata[0];
               mode_periodic <= cfg_wdata[1];
            end
            CSEL_PERIOD: period <= cfg_wdata[PERIOD_W-1:0];
            default: ;
         endcase
      end
   end

   assign mode_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CSEL_MODE);

   logic addr_ok, type_ok, resp_ok;
   assign addr_ok = ((obs_addr ^ addr_cmp) & addr_mask) == '0;
   assign type_ok = ((obs_type ^ type_cmp) & type_mask) == '0;
   assign resp_ok = ((obs_resp ^ resp_cmp) & resp_mask) == '0;
   assign hit     = obs_valid && addr_ok && type_ok && resp_ok;
endmodule

// File: rtl/stamp_tick_gen.sv
module stamp_tick_gen #(
   parameter int PERIOD_W    = 16,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   generate
      if (PERIODIC_EN) begin : g_timer
         logic [PERIOD_W-1:0] cnt;
         logic [PERIOD_W-1:0] lim;
         assign lim  = (period == '0) ? '0 : period - 1'b1;
         assign tick = run && !restart && (cnt >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (restart || !run)    cnt <= '0;
            else if (cnt >= lim)         cnt <= '0;
            else                         cnt <= cnt + 1'b1;
         end

         assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && lim != '0) |=> !tick);
      end else begin : g_no_timer
         assign tick = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/stamp_gv_client.sv
module stamp_gv_client
   import stamper_pkg::*;
#(
   parameter int NUM_FIELDS = 5,
   parameter int FIELD_W    = 32,
   parameter int OWN_IDX    = 0,
   localparam int VEC_W     = NUM_FIELDS * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             idle,
   output logic             gv_req,
   input  logic             gv_gnt,
   input  logic [VEC_W-1:0] gv_rdata,
   output logic             gv_we,
   output logic [VEC_W-1:0] gv_wdata
);
   gv_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else begin
         case (state)
            ST_IDLE: if (start)  state <= ST_REQ;
            ST_REQ:  if (gv_gnt) state <= ST_IDLE;
            default:             state <= ST_IDLE;
         endcase
      end
   end

   assign idle   = (state == ST_IDLE);
   assign gv_req = (state == ST_REQ);
   assign gv_we  = gv_req && gv_gnt;

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
         if (f == OWN_IDX) begin : g_own
            assign gv_wdata[f*FIELD_W +: FIELD_W] = gv_rdata[f*FIELD_W +: FIELD_W] + 1'b1;
         end else begin : g_pass
            assign gv_wdata[f*FIELD_W +: FIELD_W] = gv_rdata[f*FIELD_W +: FIELD_W];
         end
      end
   endgenerate

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gv_req && !gv_gnt) |=> gv_req);
   assert_we_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gv_we |-> gv_gnt);
endmodule

// File: rtl/stamp_rec_slot.sv
module stamp_rec_slot #(
   parameter int VEC_W  = 160,
   parameter int INFO_W = 41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [VEC_W-1:0]  load_vec,
   input  logic [INFO_W-1:0] load_info,
   input  logic              rec_ready,
   input  logic              ovf_set,
   input  logic              ovf_clr,
   output logic              rec_valid,
   output logic [VEC_W-1:0]  rec_vec,
   output logic [INFO_W-1:0] rec_info,
   output logic              ovf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid <= 1'b0;
         rec_vec   <= '0;
         rec_info  <= '0;
      end else if (load) begin
         rec_valid <= 1'b1;
         rec_vec   <= load_vec;
         rec_info  <= load_info;
      end else if (rec_ready) begin
         rec_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (ovf_set) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
   end

   assert_rec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_vec) && $stable(rec_info)));
   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/bus_event_stamper.sv
module bus_event_stamper
   import stamper_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int NUM_FIELDS  = 5,
   parameter int FIELD_W     = 32,
   parameter int OWN_IDX     = 0,
   parameter int PERIOD_W    = 16,
   parameter bit PERIODIC_EN = 1'b1,
   localparam int VEC_W      = NUM_FIELDS * FIELD_W,
   localparam int INFO_W     = 1 + RESP_W + TYPE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              obs_valid,
   input  logic [ADDR_W-1:0] obs_addr,
   input  logic [1:0]        obs_trans,
   input  logic [2:0]        obs_burst,
   input  logic              obs_lock,
   input  logic [1:0]        obs_resp,
   output logic              gv_req,
   input  logic              gv_gnt,
   input  logic [VEC_W-1:0]  gv_rdata,
   output logic              gv_we,
   output logic [VEC_W-1:0]  gv_wdata,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic              rec_kind,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [5:0]        rec_type,
   output logic [1:0]        rec_resp,
   output logic [VEC_W-1:0]  rec_vec,
   output logic              rec_overflow
);
   generate
      if (OWN_IDX < 0 || OWN_IDX >= NUM_FIELDS) begin : g_bad_idx
         $error("OWN_IDX must name one of the NUM_FIELDS fields");
      end
      if (ADDR_W < 1 || ADDR_W > CFG_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..CFG_W");
      end
      if (PERIOD_W < 1 || PERIOD_W > CFG_W) begin : g_bad_period
         $error("PERIOD_W must lie in 1..CFG_W");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("FIELD_W must be positive");
      end
   endgenerate

   logic [TYPE_W-1:0]   obs_type;
   logic                mode_en, mode_periodic, mode_wr, hit, tick;
   logic [PERIOD_W-1:0] period;
   logic                idle, trig, slot_free, accept, drop;
   logic [INFO_W-1:0]   evt_info, rec_info;

   assign obs_type = {obs_lock, obs_burst, obs_trans};

   stamp_trig_unit #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_trig (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
      .obs_valid, .obs_addr, .obs_type, .obs_resp,
      .mode_en, .mode_periodic, .mode_wr, .period, .hit
   );

   stamp_tick_gen #(.PERIOD_W(PERIOD_W), .PERIODIC_EN(PERIODIC_EN)) u_tick (
      .clk, .rst_n,
      .run(mode_en && mode_periodic), .restart(mode_wr), .period, .tick
   );

   assign trig      = mode_en && (mode_periodic ? tick : hit);
   assign slot_free = !rec_valid || rec_ready;
   assign accept    = trig && idle && slot_free;
   assign drop      = trig && !accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_info <= '0;
      else if (accept)
         evt_info <= {(mode_periodic ? KIND_TICK : KIND_MATCH), obs_resp, obs_type, obs_addr};
   end

   stamp_gv_client #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .OWN_IDX(OWN_IDX)) u_gv (
      .clk, .rst_n, .start(accept), .idle,
      .gv_req, .gv_gnt, .gv_rdata, .gv_we, .gv_wdata
   );

   stamp_rec_slot #(.VEC_W(VEC_W), .INFO_W(INFO_W)) u_slot (
      .clk, .rst_n, .load(gv_we), .load_vec(gv_wdata), .load_info(evt_info),
      .rec_ready, .ovf_set(drop), .ovf_clr(mode_wr),
      .rec_valid, .rec_vec, .rec_info, .ovf(rec_overflow)
   );

   assign {rec_kind, rec_resp, rec_type, rec_addr} = rec_info;

   assert_rec_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gv_we |=> (rec_valid && rec_vec == $past(gv_wdata)));
   assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |-> !accept);
   assert_drop_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && idle) |=> !gv_req);
endmodule

// File: tb/bus_event_stamper_tb.sv
module bus_event_stamper_tb;
   localparam int AW = 32;
   localparam int NF = 5;
   localparam int FW = 32;
   localparam int VW = NF * FW;
   localparam int OWN = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          cfg_we;
   logic [2:0]    cfg_sel;
   logic [31:0]   cfg_wdata;
   logic          obs_valid;
   logic [AW-1:0] obs_addr;
   logic [1:0]    obs_trans;
   logic [2:0]    obs_burst;
   logic          obs_lock;
   logic [1:0]    obs_resp;
   logic          gv_req, gv_gnt, gv_we;
   logic [VW-1:0] gv_rdata, gv_wdata;
   logic          rec_valid, rec_ready, rec_kind, rec_overflow;
   logic [AW-1:0] rec_addr;
   logic [5:0]    rec_type;
   logic [1:0]    rec_resp;
   logic [VW-1:0] rec_vec;

   logic          gnt_en;
   logic          preset_en;
   logic [VW-1:0] preset_val;
   logic [VW-1:0] gstore;

   assign gv_gnt   = gv_req && gnt_en;
   assign gv_rdata = gstore;

   always @(posedge clk) begin
      if (preset_en)  gstore <= preset_val;
      else if (gv_we) gstore <= gv_wdata;
   end

   bus_event_stamper #(.ADDR_W(AW), .NUM_FIELDS(NF), .FIELD_W(FW), .OWN_IDX(OWN)) u_dut (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
      .obs_valid, .obs_addr, .obs_trans, .obs_burst, .obs_lock, .obs_resp,
      .gv_req, .gv_gnt, .gv_rdata, .gv_we, .gv_wdata,
      .rec_valid, .rec_ready, .rec_kind, .rec_addr, .rec_type, .rec_resp,
      .rec_vec, .rec_overflow
   );

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] bump(input logic [VW-1:0] v);
      logic [VW-1:0] r;
      r = v;
      r[OWN*FW +: FW] = v[OWN*FW +: FW] + 32'd1;
      return r;
   endfunction

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic beat(input logic [AW-1:0] a, input logic [1:0] tr, input logic [2:0] bu,
                       input logic lk, input logic [1:0] rs);
      @(negedge clk);
      obs_valid = 1'b1; obs_addr = a; obs_trans = tr; obs_burst = bu;
      obs_lock = lk; obs_resp = rs;
      @(negedge clk);
      obs_valid = 1'b0;
      #1;
   endtask

   // Expects the beat just issued to be stamped with grant available.
   task automatic expect_stamp(input string tag, input logic [AW-1:0] a);
      logic [VW-1:0] exp_v;
      exp_v = bump(gstore);
      chk({tag, " gv_we"}, VW'(gv_we), VW'(1));
      chk({tag, " gv_wdata"}, gv_wdata, exp_v);
      @(negedge clk); #1;
      chk({tag, " rec_valid"}, VW'(rec_valid), VW'(1));
      chk({tag, " rec_vec"}, rec_vec, exp_v);
      chk({tag, " rec_addr"}, VW'(rec_addr), VW'(a));
   endtask

   task automatic expect_none(input string tag);
      chk({tag, " no req"}, VW'(gv_req), VW'(0));
      @(negedge clk); #1;
      chk({tag, " no rec"}, VW'(rec_valid), VW'(0));
   endtask

   task automatic t_reset;
      chk("R1 rec_valid", VW'(rec_valid), VW'(0));
      chk("R1 gv_req", VW'(gv_req), VW'(0));
      chk("R1 overflow", VW'(rec_overflow), VW'(0));
      beat(32'h0, 2'd2, 3'd0, 1'b0, 2'd0);
      expect_none("R11 disabled");
   endtask

   task automatic t_addr;
      cfg_write(3'd0, 32'hFFFF_F000);
      cfg_write(3'd1, 32'h4000_1000);
      cfg_write(3'd4, 32'h1);
      beat(32'h4000_1ABC, 2'd2, 3'd0, 1'b0, 2'd0);
      expect_stamp("R2 addr hit", 32'h4000_1ABC);
      chk("R7 kind match", VW'(rec_kind), VW'(0));
      beat(32'h4000_2000, 2'd2, 3'd0, 1'b0, 2'd0);
      expect_none("R2 addr miss");
      @(negedge clk);
      obs_addr = 32'h4000_1000; obs_valid = 1'b0;
      @(negedge clk); #1;
      expect_none("R2 valid low");
      cfg_write(3'd0, 32'h0);
   endtask

   task automatic t_type;
      cfg_write(3'd2, {18'd0, 6'b111100, 2'd0, 6'b101100});
      beat(32'h10, 2'd2, 3'd3, 1'b1, 2'd0);
      expect_stamp("R3 type hit", 32'h10);
      chk("R7 rec_type", VW'(rec_type), VW'(6'b101110));
      beat(32'h10, 2'd2, 3'd3, 1'b0, 2'd0);
      expect_none("R3 lock miss");
      beat(32'h10, 2'd2, 3'd1, 1'b1, 2'd0);
      expect_none("R3 burst miss");
      cfg_write(3'd2, 32'h0);
   endtask

   task automatic t_resp;
      cfg_write(3'd3, {22'd0, 2'b11, 6'd0, 2'b01});
      beat(32'h20, 2'd2, 3'd0, 1'b0, 2'b01);
      expect_stamp("R4 error resp hit", 32'h20);
      chk("R7 rec_resp", VW'(rec_resp), VW'(2'b01));
      beat(32'h20, 2'd2, 3'd0, 1'b0, 2'b00);
      expect_none("R4 okay resp miss");
      cfg_write(3'd3, 32'h0);
   endtask

   task automatic t_wrap;
      logic [VW-1:0] v;
      v = gstore;
      v[OWN*FW +: FW] = 32'hFFFF_FFFF;
      v[0 +: FW] = 32'd7;
      @(negedge clk);
      preset_en = 1'b1; preset_val = v;
      @(negedge clk);
      preset_en = 1'b0;
      beat(32'h30, 2'd2, 3'd0, 1'b0, 2'd0);
      chk("R6 own field wraps", VW'(gv_wdata[OWN*FW +: FW]), VW'(0));
      chk("R5 other field kept", VW'(gv_wdata[0 +: FW]), VW'(7));
      @(negedge clk);
   endtask

   task automatic t_grant_wait;
      logic [VW-1:0] exp_v;
      gnt_en = 1'b0;
      beat(32'h40, 2'd2, 3'd0, 1'b0, 2'd0);
      exp_v = bump(gstore);
      for (int i = 0; i < 3; i++) begin
         chk("R5 req held", VW'(gv_req), VW'(1));
         chk("R5 no write without grant", VW'(gv_we), VW'(0));
         @(negedge clk); #1;
      end
      beat(32'h44, 2'd2, 3'd0, 1'b0, 2'd0);
      chk("R9 drop during stamp", VW'(rec_overflow), VW'(1));
      gnt_en = 1'b1;
      #1;
      chk("R5 write on grant", VW'(gv_we), VW'(1));
      chk("R5 wdata", gv_wdata, exp_v);
      @(negedge clk); #1;
      chk("R7 record after grant", rec_vec, exp_v);
      chk("R9 first addr kept", VW'(rec_addr), VW'(32'h40));
      cfg_write(3'd4, 32'h1);
      #1;
      chk("R9 cleared by mode write", VW'(rec_overflow), VW'(0));
   endtask

   task automatic t_backpressure;
      logic [VW-1:0] exp_v;
      rec_ready = 1'b0;
      beat(32'h50, 2'd2, 3'd0, 1'b0, 2'd0);
      exp_v = bump(gstore);
      @(negedge clk); #1;
      for (int i = 0; i < 3; i++) begin
         chk("R8 held valid", VW'(rec_valid), VW'(1));
         chk("R8 held vec", rec_vec, exp_v);
         @(negedge clk); #1;
      end
      beat(32'h54, 2'd2, 3'd0, 1'b0, 2'd0);
      chk("R9 overflow set", VW'(rec_overflow), VW'(1));
      chk("R9 no access on drop", VW'(gv_req), VW'(0));
      chk("R9 pending kept", rec_vec, exp_v);
      // Same edge: downstream drains while a new trigger arrives.
      @(negedge clk);
      rec_ready = 1'b1;
      obs_valid = 1'b1; obs_addr = 32'h58;
      @(negedge clk);
      obs_valid = 1'b0;
      #1;
      chk("R12 taken", VW'(gv_req), VW'(1));
      chk("R12 new vec", gv_wdata, bump(exp_v));
      @(negedge clk); #1;
      chk("R12 new record", rec_vec, bump(exp_v));
      chk("R12 new addr", VW'(rec_addr), VW'(32'h58));
      cfg_write(3'd4, 32'h1);
      #1;
      chk("R9 clear", VW'(rec_overflow), VW'(0));
      rec_ready = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_periodic;
      int gap;
      logic [VW-1:0] first_v;
      cfg_write(3'd5, 32'd8);
      cfg_write(3'd4, 32'h3);
      gap = 0;
      for (int i = 0; i < 40 && !rec_valid; i++) begin
         @(negedge clk); #1;
      end
      chk("R10 tick record", VW'(rec_valid), VW'(1));
      chk("R10 kind tick", VW'(rec_kind), VW'(1));
      first_v = rec_vec;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #1;
         gap++;
         if (rec_valid) break;
      end
      chk("R10 period gap", VW'(gap), VW'(8));
      chk("R10 next stamp", rec_vec, bump(first_v));
      cfg_write(3'd4, 32'h0);
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      obs_valid = 1'b0; obs_addr = '0; obs_trans = '0; obs_burst = '0;
      obs_lock = 1'b0; obs_resp = '0; rec_ready = 1'b1; gnt_en = 1'b1;
      preset_en = 1'b1; preset_val = {32'd5, 32'd4, 32'd100, 32'd2, 32'd1};
      repeat (3) @(negedge clk);
      rst_n = 1'b1; preset_en = 1'b0;
      #1;
      t_reset();
      t_addr();
      t_type();
      t_resp();
      t_wrap();
      t_grant_wait();
      t_backpressure();
      t_periodic();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule